// File: doc/BRIEF.md
# Multichannel Audio Sample Formatter

This block sits between a ring-buffer reader and a digital display audio link. It accepts interleaved PCM words, one channel after another within each sample period, and converts each container into a 24-bit audio word. Each output word carries its channel index and a flag that marks the first channel of a frame. Four configuration bits choose the container width (16 or 32 bits), where the sample MSB sits inside a 32-bit container (bit 23 or bit 31), whether odd channel counts are padded with an extra zero channel, and what happens when the link wants data that has not yet arrived: zero-valued silence samples, or a null-packet indication with no sample.

Configuration and channel count are captured only while `enable` is low, and they stay fixed for the whole enabled period. Dropping `enable` flushes the output register and restarts the frame at channel 0. An underrun sets a sticky flag that stays set until a one is written to `underrun_clr`. `MAX_CH` must be even so that a padded frame fits the channel index.

Top module: `pcm_link_formatter`

## Requirements
- R1: After reset, `out_valid`, `in_ready`, `null_pkt` and `underrun_flag` are all low.
- R2: With a 32-bit container and the MSB-high bit clear, the output word equals input bits [23:0].
- R3: With a 32-bit container and the MSB-high bit set, the output word equals input bits [31:8], and the low 8 bits are discarded.
- R4: With the 16-bit container bit set, the output word equals {input bits [15:0], 8'h00}, whatever the MSB-high bit holds.
- R5: Output words carry channel indexes 0, 1, … frame length − 1 in input order, then wrap to 0. `out_sof` is high exactly on index 0.
- R6: When the channel count N is odd and padding is enabled (`cfg_no_pad`=0), a zero word with index N closes each frame, and no input word is consumed for it.
- R7: With `cfg_no_pad`=1, an odd count N gives frames of exactly N words with no padding.
- R8: An underrun occurs when the block is enabled, `out_ready` is high, the output register is empty or draining, the current slot is not a padding slot, and `in_valid` is low. With `cfg_silence`=1, each underrun emits a zero word and the channel index advances.
- R9: With `cfg_silence`=0, an underrun emits no word, and `null_pkt` is high in the cycle after each underrun cycle.
- R10: `underrun_flag` rises after any underrun and holds until `underrun_clr` is high in a cycle with no underrun.
- R11: Changes to the configuration inputs or `cfg_chans` while `enable` is high have no effect on the stream.
- R12: While `out_valid` is high and `out_ready` is low, the output word, index and frame flag hold stable, and no word is lost or duplicated.
- R13: The cycle after `enable` falls, `out_valid` is low, and the next enabled run starts at channel index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; configuration is captured while low |
| cfg_half | input | 1 | 1: 16-bit containers, 0: 32-bit containers |
| cfg_msb_top | input | 1 | 32-bit container MSB at bit 31 (1) or bit 23 (0) |
| cfg_no_pad | input | 1 | 1: no padding channel for odd counts |
| cfg_silence | input | 1 | Underrun policy: 1 zero words, 0 null packets |
| cfg_chans | input | $clog2(MAX_CH+1) | Channel count per frame, 1..MAX_CH |
| in_valid | input | 1 | Input word valid |
| in_data | input | IN_W | Input container |
| in_ready | output | 1 | Input word accepted this cycle |
| out_ready | input | 1 | Link accepts an output word |
| out_valid | output | 1 | Output word valid |
| out_data | output | OUT_W | 24-bit audio word |
| out_chan | output | $clog2(MAX_CH) | Channel index of the word |
| out_sof | output | 1 | First channel of a frame |
| null_pkt | output | 1 | Null packet to be sent instead of a sample |
| underrun_flag | output | 1 | Sticky underrun indication |
| underrun_clr | input | 1 | Write-one-to-clear for the underrun flag |

## Verification
The hardest case to reach is the padding slot when the input is stalled: the zero channel must appear without consuming a word, and it must not be taken for an underrun. Only a run that ends its input exactly at a frame boundary shows this. The stimulus feeds whole three-channel frames and then stops feeding with `out_ready` held high. The trailing pad word must still appear, and null packets must follow it. Backpressure is combined with an attempt to reconfigure mid-run by toggling `out_ready` every cycle while the count inputs change.

// File: rtl/afmt_pkg.sv
package afmt_pkg;

    typedef struct packed {
        logic half;     // 16-bit containers
        logic msb_top;  // 32-bit container MSB at bit 31
        logic no_pad;   // no padding channel for odd counts
        logic silence;  // underrun sends zero words
    } fmt_cfg_t;

endpackage

// File: rtl/afmt_align.sv
module afmt_align #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 24
) (
    input  logic             half,
    input  logic             msb_top,
    input  logic [IN_W-1:0]  word,
    output logic [OUT_W-1:0] sample
);
    localparam int HALF_W = IN_W / 2;
    localparam int FILL_W = OUT_W - HALF_W;
    localparam int DROP_W = IN_W - OUT_W;

    always_comb begin
        if (half) begin
            sample = {word[HALF_W-1:0], {FILL_W{1'b0}}};
        end else if (msb_top) begin
            sample = word[IN_W-1:DROP_W];
        end else begin
            sample = word[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/afmt_chan_seq.sv
module afmt_chan_seq #(
    parameter int MAX_CH = 8,
    localparam int CW = $clog2(MAX_CH + 1),
    localparam int IW = $clog2(MAX_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] chans,
    input  logic          no_pad,
    input  logic          adv,
    output logic [IW-1:0] ch,
    output logic [CW-1:0] frame_len,
    output logic          pad_slot
);
    typedef struct packed {
        logic [IW-1:0] ch;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    padded;
    logic    last;

    always_comb begin
        padded    = chans[0] && !no_pad;
        frame_len = chans + CW'(padded);
        last      = (CW'(st_q.ch) == frame_len - CW'(1));
        pad_slot  = padded && (CW'(st_q.ch) == chans);
        st_d      = st_q;
        if (!enable) begin
            st_d.ch = '0;
        end else if (adv) begin
            st_d.ch = last ? '0 : st_q.ch + IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ch = st_q.ch;

    // R13: index returns to zero whenever the block is idle
    a_r13_idx_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.ch == '0));
endmodule

// File: rtl/pcm_link_formatter.sv
module pcm_link_formatter #(
    parameter int MAX_CH = 8,
    parameter int IN_W   = 32,
    parameter int OUT_W  = 24,
    localparam int CW = $clog2(MAX_CH + 1),
    localparam int IW = $clog2(MAX_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_half,
    input  logic             cfg_msb_top,
    input  logic             cfg_no_pad,
    input  logic             cfg_silence,
    input  logic [CW-1:0]    cfg_chans,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             in_ready,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic [IW-1:0]    out_chan,
    output logic             out_sof,
    output logic             null_pkt,
    output logic             underrun_flag,
    input  logic             underrun_clr
);
    import afmt_pkg::*;

    typedef struct packed {
        fmt_cfg_t         cfg;
        logic [CW-1:0]    chans;
        logic             vld;
        logic [OUT_W-1:0] data;
        logic [IW-1:0]    chan;
        logic             sof;
        logic             nul;
        logic             uflag;
    } fmt_st_t;

    fmt_st_t          st_d, st_q;
    logic [OUT_W-1:0] aligned;
    logic [IW-1:0]    cur_ch;
    logic [CW-1:0]    frame_len;
    logic             pad_slot;
    logic             can_load;
    logic             under;
    logic             emit;

    afmt_align #(.IN_W(IN_W), .OUT_W(OUT_W)) u_align (
        .half    (st_q.cfg.half),
        .msb_top (st_q.cfg.msb_top),
        .word    (in_data),
        .sample  (aligned)
    );

    afmt_chan_seq #(.MAX_CH(MAX_CH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .chans     (st_q.chans),
        .no_pad    (st_q.cfg.no_pad),
        .adv       (emit),
        .ch        (cur_ch),
        .frame_len (frame_len),
        .pad_slot  (pad_slot)
    );

    always_comb begin
        can_load = !st_q.vld || out_ready;
        in_ready = enable && can_load && !pad_slot;
        under    = enable && can_load && !pad_slot && !in_valid && out_ready;
        emit     = enable && can_load &&
                   (pad_slot || in_valid || (under && st_q.cfg.silence));

        st_d = st_q;
        if (!enable) begin
            st_d.cfg   = '{half: cfg_half, msb_top: cfg_msb_top,
                           no_pad: cfg_no_pad, silence: cfg_silence};
            st_d.chans = cfg_chans;
            st_d.vld   = 1'b0;
        end else if (emit) begin
            st_d.vld  = 1'b1;
            st_d.data = (pad_slot || !in_valid) ? '0 : aligned;
            st_d.chan = cur_ch;
            st_d.sof  = (cur_ch == '0);
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end

        st_d.nul   = under && !st_q.cfg.silence;
        st_d.uflag = under ? 1'b1 : (underrun_clr ? 1'b0 : st_q.uflag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid     = st_q.vld;
    assign out_data      = st_q.data;
    assign out_chan      = st_q.chan;
    assign out_sof       = st_q.sof;
    assign null_pkt      = st_q.nul;
    assign underrun_flag = st_q.uflag;

    // R12: a stalled word holds still
    a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_sof)));

    // R5: frame flag marks channel zero
    a_r5_sof_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sof == (out_chan == '0)));

    // R5: index stays inside the frame
    a_r5_chan_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && frame_len != '0) |-> (CW'(out_chan) < frame_len));

    // R13: disabling empties the output register
    a_r13_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !out_valid);

    // R9: a null packet always comes with the sticky flag
    a_r9_null_flags: assert property (@(posedge clk) disable iff (!rst_n)
        null_pkt |-> underrun_flag);

    // R10: flag holds until cleared
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_flag && !underrun_clr) |=> underrun_flag);
endmodule

// File: tb/sim_pcm_link_formatter.sv
`timescale 1ns/1ps
module sim_pcm_link_formatter;
    localparam int MAX_CH = 8;
    localparam int CW = $clog2(MAX_CH + 1);
    localparam int IW = $clog2(MAX_CH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic cfg_half = 1'b0, cfg_msb_top = 1'b0, cfg_no_pad = 1'b0, cfg_silence = 1'b0;
    logic [CW-1:0] cfg_chans = CW'(2);
    logic in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic in_ready;
    logic out_ready = 1'b0;
    logic out_valid;
    logic [23:0] out_data;
    logic [IW-1:0] out_chan;
    logic out_sof, null_pkt, underrun_flag;
    logic underrun_clr = 1'b0;

    pcm_link_formatter #(.MAX_CH(MAX_CH)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_half(cfg_half), .cfg_msb_top(cfg_msb_top), .cfg_no_pad(cfg_no_pad),
        .cfg_silence(cfg_silence), .cfg_chans(cfg_chans),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_chan(out_chan), .out_sof(out_sof), .null_pkt(null_pkt),
        .underrun_flag(underrun_flag), .underrun_clr(underrun_clr)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // source and sink models
    logic [31:0] src [16];
    int src_n = 0;
    int src_idx = 0;
    int rdy_mode = 0;   // 0 low, 1 high, 2 toggling
    bit in_fire = 1'b0;
    logic [23:0] cap_d [32];
    logic [IW-1:0] cap_c [32];
    logic cap_s [32];
    int cap_n = 0;
    int nul_n = 0;
    int cyc = 0;

    always @(negedge clk) begin
        in_fire = in_valid && in_ready;
        if (rst_n && out_valid && out_ready && cap_n < 32) begin
            cap_d[cap_n] = out_data;
            cap_c[cap_n] = out_chan;
            cap_s[cap_n] = out_sof;
            cap_n++;
        end
        if (null_pkt) nul_n++;
    end

    always @(posedge clk) begin
        #1;
        cyc++;
        if (in_fire) src_idx++;
        in_valid = (src_idx < src_n);
        in_data  = (src_idx < 16) ? src[src_idx] : 32'h0;
        out_ready = (rdy_mode == 1) || (rdy_mode == 2 && cyc[0]);
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic setup(input int chans, input bit half, input bit msb, input bit nopad,
                         input bit sil, input int mode, input int n);
        @(posedge clk); #2;
        enable = 1'b0;
        cfg_chans = CW'(chans); cfg_half = half; cfg_msb_top = msb;
        cfg_no_pad = nopad; cfg_silence = sil;
        rdy_mode = mode;
        src_n = n; src_idx = 0;
        repeat (2) @(posedge clk);
        #2;
        cap_n = 0; nul_n = 0;
    endtask

    // {half, msb_top, container, expected word}
    localparam logic [57:0] VEC [8] = '{
        {1'b0, 1'b0, 32'hAB123456, 24'h123456},
        {1'b0, 1'b0, 32'h00800001, 24'h800001},
        {1'b0, 1'b1, 32'h12345678, 24'h123456},
        {1'b0, 1'b1, 32'hFFFFFF00, 24'hFFFFFF},
        {1'b0, 1'b1, 32'h000000FF, 24'h000000},
        {1'b1, 1'b0, 32'hDEAD8001, 24'h800100},
        {1'b1, 1'b1, 32'h00007FFF, 24'h7FFF00},
        {1'b1, 1'b0, 32'hFFFF0000, 24'h000000}
    };

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !in_ready && !null_pkt && !underrun_flag, "R1 reset outputs",
              {out_valid, in_ready, null_pkt, underrun_flag}, 0);
        #1 rst_n = 1'b1;

        // format table walk (R2 R3 R4), flush check R13
        for (int v = 0; v < 8; v++) begin
            src[0] = VEC[v][55:24];
            setup(2, VEC[v][57], VEC[v][56], 1'b1, 1'b0, 0, 1);
            @(posedge clk); #1 enable = 1'b1;
            @(posedge clk); @(negedge clk);
            check(out_valid && out_data == VEC[v][23:0],
                  VEC[v][57] ? "R4 half container" : (VEC[v][56] ? "R3 msb high" : "R2 msb low"),
                  {8'h0, out_data}, {8'h0, VEC[v][23:0]});
            check(out_chan == 0 && out_sof, "R5 first word index", {out_chan, out_sof}, 1);
            @(posedge clk); #1 enable = 1'b0;
            @(posedge clk); @(negedge clk);
            check(!out_valid, "R13 flush on disable", out_valid, 0);
        end

        // stereo under toggling backpressure, reconfig attempt mid-run
        for (int i = 0; i < 4; i++) src[i] = 32'hA5000010 + i;
        setup(2, 0, 0, 0, 0, 2, 4);
        @(posedge clk); #1 enable = 1'b1;
        @(posedge clk); #1 cfg_chans = CW'(3); cfg_half = 1'b1;
        repeat (20) @(posedge clk);
        #1 enable = 1'b0;
        @(negedge clk);
        check(cap_n == 4, "R12 no loss or duplicate", cap_n, 4);
        for (int i = 0; i < 4; i++) begin
            check(cap_d[i] == src[i][23:0], "R12 R11 stereo data", {8'h0, cap_d[i]}, {8'h0, src[i][23:0]});
            check(cap_c[i] == IW'(i % 2) && cap_s[i] == (i % 2 == 0), "R11 R5 stereo index",
                  {cap_c[i], cap_s[i]}, {IW'(i % 2), (i % 2 == 0)});
        end

        // three channels padded, null mode
        for (int i = 0; i < 6; i++) src[i] = 32'h00C00100 + i;
        setup(3, 0, 0, 0, 0, 1, 6);
        @(posedge clk); #1 enable = 1'b1;
        repeat (16) @(posedge clk);
        #1 enable = 1'b0;
        @(negedge clk);
        check(cap_n == 8, "R6 padded word count", cap_n, 8);
        for (int i = 0; i < 8; i++) begin
            logic [23:0] e;
            e = (i % 4 == 3) ? 24'h0 : src[(i / 4) * 3 + (i % 4)][23:0];
            check(cap_d[i] == e && cap_c[i] == IW'(i % 4), "R6 padded frame",
                  {cap_c[i], cap_d[i]}, {IW'(i % 4), e});
        end
        check(nul_n > 0, "R9 null packets after drain", nul_n, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(underrun_flag, "R10 flag sticky", underrun_flag, 1);
        @(posedge clk); #1 underrun_clr = 1'b1;
        @(posedge clk); #1 underrun_clr = 1'b0;
        @(negedge clk);
        check(!underrun_flag, "R10 flag cleared", underrun_flag, 0);

        // three channels, padding off
        for (int i = 0; i < 6; i++) src[i] = 32'h00300000 + i;
        setup(3, 0, 0, 1, 0, 1, 6);
        @(posedge clk); #1 enable = 1'b1;
        repeat (14) @(posedge clk);
        #1 enable = 1'b0;
        @(negedge clk);
        check(cap_n == 6, "R7 unpadded count", cap_n, 6);
        for (int i = 0; i < 6; i++)
            check(cap_c[i] == IW'(i % 3) && cap_d[i] == src[i][23:0], "R7 unpadded frame",
                  {cap_c[i], cap_d[i]}, {IW'(i % 3), src[i][23:0]});

        // silence on underrun
        @(posedge clk); #1 underrun_clr = 1'b1;
        @(posedge clk); #1 underrun_clr = 1'b0;
        setup(2, 0, 0, 0, 1, 1, 0);
        @(posedge clk); #1 enable = 1'b1;
        repeat (6) @(posedge clk);
        #1 enable = 1'b0;
        @(negedge clk);
        check(cap_n >= 4, "R8 silence words", cap_n, 4);
        for (int i = 0; i < 4; i++)
            check(cap_d[i] == 0 && cap_c[i] == IW'(i % 2) && cap_s[i] == (i % 2 == 0),
                  "R8 silence pattern", {cap_c[i], cap_d[i]}, {IW'(i % 2), 24'h0});
        check(nul_n == 0, "R8 no null packets", nul_n, 0);
        check(underrun_flag, "R10 flag on silence underrun", underrun_flag, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule